// File: doc/BRIEF.md
# Memory-Mapped Sum Peripheral

This block is an AXI4-Lite slave for a host processor. It holds one writable register that carries two packed 16-bit unsigned operands. A second register, which software can only read, returns the sum of those operands. The sum is computed in hardware from whatever the operand register holds at the moment of the read.

Software writes both operands in one word, or it writes a single operand through the byte-lane strobes. It then reads the result word. The block implements all five channels with full handshaking. It latches the write address and the write data independently, so a master may present them in either order or together.

Top module: `axil_adder`

## Requirements
- R1: After reset, BVALID, RVALID, AWREADY-driven responses are idle (bvalid_o and rvalid_o low, awready_o, wready_o and arready_o high), and both offset 0x0 and offset 0x4 read as zero.
- R2: Registers are selected by address bits [3:2]. Address bits [1:0] are ignored, so 0x1 reaches offset 0x0 and 0x6 reaches offset 0x4.
- R3: Offset 0x0 is the operand register, with operand A in bits [15:0] and operand B in bits [31:16]. It reads back exactly what was written.
- R4: Offset 0x4 reads the 17-bit sum A+B, including the carry-out, in bits [16:0]. Bits [31:17] read as zero. For example, 0xFFFF+0xFFFF reads 0x0001FFFE.
- R5: A write to offset 0x4 completes with BRESP OKAY (2'b00) and changes nothing. A value written to offset 0x0 never appears at offset 0x4 unless it equals the sum.
- R6: Writes to offset 0x0 update only the byte lanes whose WSTRB bit is set. WSTRB bit n guards data bits [8n+7:8n].
- R7: Address and data may be accepted in either order or in the same cycle. BVALID rises on the clock edge at which the second of the two is accepted, and not before. BVALID then stays high until BREADY is seen, with BRESP OKAY.
- R8: RVALID rises on the clock edge after the read-address handshake. RDATA stays stable while RVALID is high and RREADY is low. RRESP is OKAY.
- R9: Offsets 0x8 and 0xC read as zero with OKAY. Writes to them complete with OKAY and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | 4 | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | 4 | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |

## Verification
The hardest state to reach is a half-finished write. In that state one of address or data has been accepted and held, while the other has not yet arrived. From there the bench checks that no response appears early and that the delayed half still lands on the latched address. To reach it, the bench drives address-first and data-first writes with a random gap of zero to three cycles. It mixes these with simultaneous writes, and it stalls BREADY and RREADY at random so the held-response paths are exercised as well.

// File: rtl/axil_adder_pkg.sv
package axil_adder_pkg;
  typedef enum logic [1:0] {
    IDX_OPND = 2'd0,
    IDX_SUM  = 2'd1,
    IDX_RSV2 = 2'd2,
    IDX_RSV3 = 2'd3
  } reg_idx_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // word select from byte address bits [3:2]
  function automatic reg_idx_e idx_of(input logic [3:0] addr);
    return reg_idx_e'(addr[3:2]);
  endfunction
endpackage

// File: rtl/axil_adder_wr.sv
module axil_adder_wr
  import axil_adder_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              wr_en_o,
  output reg_idx_e          wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o
);
  logic              aw_held_q, w_held_q, bvalid_q;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic              aw_hs, w_hs, aw_ok, w_ok, fire;
  logic [ADDR_W-1:0] addr_sel;

  assign awready_o = !aw_held_q && !bvalid_q;
  assign wready_o  = !w_held_q && !bvalid_q;
  assign aw_hs     = awvalid_i && awready_o;
  assign w_hs      = wvalid_i && wready_o;
  assign aw_ok     = aw_held_q || aw_hs;
  assign w_ok      = w_held_q || w_hs;
  assign fire      = aw_ok && w_ok;

  // pass-through lets a same-cycle pair complete without a holding stage
  assign addr_sel  = aw_held_q ? aw_addr_q : awaddr_i;
  assign wr_en_o   = fire;
  assign wr_idx_o  = idx_of(addr_sel[3:0]);
  assign wr_data_o = w_held_q ? w_data_q : wdata_i;
  assign wr_strb_o = w_held_q ? w_strb_q : wstrb_i;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_addr_q <= '0;
      w_data_q  <= '0;
      w_strb_q  <= '0;
    end else begin
      if (aw_hs) aw_addr_q <= awaddr_i;
      if (w_hs) begin
        w_data_q <= wdata_i;
        w_strb_q <= wstrb_i;
      end
      if (fire) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else begin
        if (aw_hs) aw_held_q <= 1'b1;
        if (w_hs)  w_held_q  <= 1'b1;
        if (bvalid_q && bready_i) bvalid_q <= 1'b0;
      end
    end
  end

  // R7
  bresp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);
  // R7
  no_early_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bvalid_o && !(aw_ok && w_ok) |=> !bvalid_o);
endmodule

// File: rtl/axil_adder_regs.sv
module axil_adder_regs
  import axil_adder_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPND_W = 16,
  localparam int STRB_W = DATA_W / 8,
  localparam int SUM_W  = OPND_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_idx_e          wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  reg_idx_e          rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] opnd_q;
  logic [OPND_W-1:0] op_a, op_b;
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] sum_word;
  logic              opnd_we;

  assign opnd_we = wr_en_i && (wr_idx_i == IDX_OPND);

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        opnd_q[8*g +: 8] <= 8'h00;
      else if (opnd_we && wr_strb_i[g])   opnd_q[8*g +: 8] <= wr_data_i[8*g +: 8];
    end
  end

  assign op_a     = opnd_q[OPND_W-1:0];
  assign op_b     = opnd_q[2*OPND_W-1:OPND_W];
  assign sum      = {1'b0, op_a} + {1'b0, op_b};
  assign sum_word = {{(DATA_W-SUM_W){1'b0}}, sum};

  always_comb begin
    unique case (rd_idx_i)
      IDX_OPND: rd_data_o = opnd_q;
      IDX_SUM:  rd_data_o = sum_word;
      default:  rd_data_o = '0;
    endcase
  end

  // R5
  sum_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_idx_i != IDX_OPND |=> $stable(opnd_q));
  // R6
  lane0_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_strb_i[0] |=> $stable(opnd_q[7:0]));
endmodule

// File: rtl/axil_adder_rd.sv
module axil_adder_rd
  import axil_adder_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output reg_idx_e          rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ar_hs;

  assign arready_o = !rvalid_q;
  assign ar_hs     = arvalid_i && arready_o;
  assign rd_idx_o  = idx_of(araddr_i[3:0]);
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ar_hs) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  // R8
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_i && arready_o |=> rvalid_o);
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
endmodule

// File: rtl/axil_adder.sv
module axil_adder
  import axil_adder_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int OPND_W = 16,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i
);
  logic              wr_en;
  reg_idx_e          wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;

  axil_adder_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bresp_o, .bvalid_o, .bready_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  axil_adder_regs #(.DATA_W(DATA_W), .OPND_W(OPND_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  axil_adder_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rresp_o, .rvalid_o, .rready_i,
    .rd_idx_o(rd_idx), .rd_data_i(rd_data)
  );
endmodule

// File: tb/tb_axil_adder.sv
module tb_axil_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  logic [31:0] op_m = '0;

  always #5 clk = ~clk;

  axil_adder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(rready)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a[3:2])
      2'd0:    return op_m;
      2'd1:    return {15'd0, ({1'b0, op_m[15:0]} + {1'b0, op_m[31:16]})};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] strb_merge(input logic [31:0] old, input logic [31:0] d,
                                             input logic [3:0] s);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (s[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order);
    bit aw_done = 0, w_done = 0, aw_hs, w_hs;
    int gap = $urandom_range(0, 3);
    int stall;
    @(negedge clk);
    if (order != 2) begin awaddr = a; awvalid = 1'b1; end
    if (order != 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
    while (!(aw_done && w_done)) begin
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(negedge clk);
      if (aw_hs) begin awvalid = 1'b0; aw_done = 1; end
      if (w_hs)  begin wvalid = 1'b0;  w_done = 1; end
      if (!(aw_done && w_done)) begin
        chk(!bvalid, "R7", "response before both halves", {31'd0, bvalid}, 32'd0);
        if (aw_done && !w_done && !wvalid) begin
          if (gap == 0) begin wdata = d; wstrb = s; wvalid = 1'b1; end else gap--;
        end
        if (w_done && !aw_done && !awvalid) begin
          if (gap == 0) begin awaddr = a; awvalid = 1'b1; end else gap--;
        end
      end
    end
    chk(bvalid && bresp == 2'b00, "R7", "bvalid/bresp after last handshake",
        {29'd0, bvalid, bresp}, 32'h4);
    stall = $urandom_range(0, 3);
    repeat (stall) begin
      @(negedge clk);
      chk(bvalid, "R7", "bvalid held under stall", {31'd0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(!bvalid, "R7", "bvalid cleared by bready", {31'd0, bvalid}, 32'd0);
    if (a[3:2] == 2'd0) op_m = strb_merge(op_m, d, s);
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    bit hs;
    logic [31:0] got, exp;
    int stall = $urandom_range(0, 3);
    exp = exp_read(a);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    do begin
      hs = arready;
      @(negedge clk);
    end while (!hs);
    arvalid = 1'b0;
    chk(rvalid && rresp == 2'b00, "R8", "rvalid one cycle after ar handshake",
        {29'd0, rvalid, rresp}, 32'h4);
    got = rdata;
    repeat (stall) begin
      @(negedge clk);
      chk(rvalid && rdata == got, "R8", "rdata held under stall", rdata, got);
    end
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk(got == exp, req, $sformatf("read addr 0x%0h", a), got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!bvalid && !rvalid && awready && wready && arready, "R1", "idle handshake outputs",
        {27'd0, bvalid, rvalid, awready, wready, arready}, 32'h7);
    do_read(4'h0, "R1");
    do_read(4'h4, "R1");

    // R3 operand readback, R4 sum
    do_write(4'h0, 32'h0003_0005, 4'hF, 0);
    do_read(4'h0, "R3");
    do_read(4'h4, "R4");
    // R4 carry out
    do_write(4'h0, 32'hFFFF_FFFF, 4'hF, 1);
    do_read(4'h4, "R4");
    chk(op_m == 32'hFFFF_FFFF && exp_read(4'h4) == 32'h0001_FFFE, "R4", "model max sum",
        exp_read(4'h4), 32'h0001_FFFE);

    // R5 write to result ignored
    do_write(4'h4, 32'hDEAD_BEEF, 4'hF, 2);
    do_read(4'h0, "R5");
    do_read(4'h4, "R5");
    do_write(4'h0, 32'h0000_1234, 4'hF, 0);
    do_read(4'h4, "R5");

    // R6 strobes: update only B
    do_write(4'h0, 32'hABCD_9999, 4'hC, 1);
    do_read(4'h0, "R6");
    do_write(4'h0, 32'h7777_0042, 4'h1, 2);
    do_read(4'h0, "R6");
    do_read(4'h4, "R6");

    // R2 low address bits ignored
    do_write(4'h3, 32'h0100_0200, 4'hF, 0);
    do_read(4'h1, "R2");
    do_read(4'h6, "R2");

    // R9 unmapped offsets
    do_write(4'h8, 32'h1111_1111, 4'hF, 1);
    do_write(4'hC, 32'h2222_2222, 4'hF, 2);
    do_read(4'h8, "R9");
    do_read(4'hC, "R9");
    do_read(4'h0, "R9");

    // R7 random ordering, random traffic
    for (int i = 0; i < 80; i++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1)
        do_write(a, $urandom, 4'($urandom_range(0, 15)), $urandom_range(0, 2));
      else
        do_read(a, "R7");
    end
    do_read(4'h0, "R3");
    do_read(4'h4, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule